// File: doc/BRIEF.md
# Video Pixel Output Formatter

This block sits at the end of a video decoder. It takes 4:2:2 samples from an upstream stage and puts them on a 16-bit pixel bus. It runs on a clock at twice the pixel rate, so every pixel owns a slot of two clock cycles.

The bus has two layouts. In the wide layout, luma and chroma travel together on one 16-bit word. In the narrow layout, chroma and then luma travel one after the other on the upper byte. The block also produces a data-valid strobe and blanking, horizontal sync, vertical sync and field flags. Every output leaves a register. A small line and frame counter, set through timing inputs, decides which slots carry active video.

Samples come in on a valid/ready interface, and the formatter is the sink. Ready is driven by the video timing alone and is high only in the first cycle of an active slot. The source cannot hold the output back. If a sample is not offered when ready is high, that slot is sent as blanking and the stream goes on. Luma and chroma arrive as one pair per pixel. The source alternates the chroma member between Cb and Cr, starting with Cb at the first active pixel of each line.

Top module: `vfmt_out`

## Requirements
- R1: While reset is held, the outputs are: bus = 16'h1080, blank = 1, hsync = vsync = field = 0, and data-valid at its inactive level (equal to `dv_active_low`).
- R2: Each slot lasts two clock cycles, and a line has `line_slots` slots. A slot is active when its index within the line is below `act_slots` and the line index is in the range `line_first` to `line_last`, inclusive. Each output reflects the counter state one clock earlier, and blank is 0 exactly on active slots that carry a sample.
- R3: In narrow mode (`wide_mode` = 0), a filled slot carries chroma in bus[15:8] in its first cycle and luma in its second cycle. bus[7:0] is 0. Over a line, this gives the order Cb0, Y0, Cr0, Y1, Cb2, and so on.
- R4: In wide mode, a filled slot holds {luma, chroma} on bus[15:8] and bus[7:0] for both cycles.
- R5: A blank slot carries blanking codes. In wide mode the bus is 16'h1080 (luma code 16, chroma code 128). In narrow mode the bus is 16'h8000 in the first cycle and 16'h1000 in the second.
- R6: A transfer happens in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only in the first cycle of an active slot. If `in_valid` is 0 in that cycle, the whole slot is sent blank with blanking codes and data-valid stays low.
- R7: With `dv_all_lines` = 0 and `dv_no_duty` = 0, data-valid is high only in the first cycle of each filled slot. This toggles it at 50% duty.
- R8: With `dv_all_lines` = 0 and `dv_no_duty` = 1, data-valid is high in both cycles of each filled slot.
- R9: With `dv_all_lines` = 1, data-valid is high in the first cycle of every slot on every line, whatever the value of `dv_no_duty`. The one exception is a starved active slot, where it stays low.
- R10: `dv_active_low` = 1 inverts the data-valid pin.
- R11: hsync is high during the last slot of each line, and vsync is high during the last line of each frame. The field flag toggles when the frame wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit multiplexed |
| dv_all_lines | input | 1 | Strobe runs on every slot of every line |
| dv_no_duty | input | 1 | Strobe covers whole filled slot |
| dv_active_low | input | 1 | Invert data-valid pin |
| act_slots | input | HW | Active slots per line |
| line_slots | input | HW | Total slots per line |
| line_first | input | VW | First active line |
| line_last | input | VW | Last active line |
| frame_lines | input | VW | Lines per frame |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Formatter takes a pair this cycle |
| in_y | input | 8 | Luma sample |
| in_c | input | 8 | Chroma sample (Cb/Cr alternating) |
| pix_o | output | 16 | Pixel bus |
| blank_o | output | 1 | Slot carries blanking |
| hsync_o | output | 1 | Last slot of line |
| vsync_o | output | 1 | Last line of frame |
| field_o | output | 1 | Field flag |
| dvalid_o | output | 1 | Data-valid strobe |

## Verification
Two events can fall in the same slot. One is a starved active slot, which must force blanking codes. The other is the all-lines strobe, which would otherwise pulse in that slot. The bench withholds `in_valid` at two chosen ready opportunities while the all-lines mode is selected with inverted polarity. A scoreboard records each such opportunity as untaken, and the bench expects blank codes on the bus and the strobe held at its inactive level for both cycles of that slot. The bench also checks the last slot of the last line of a frame, where hsync, vsync and the field toggle all coincide.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;
  localparam logic [7:0] Y_BLANK = 8'h10;
  localparam logic [7:0] C_BLANK = 8'h80;

  typedef struct packed {
    logic [7:0] y;
    logic [7:0] c;
  } pix_t;
endpackage

// File: rtl/vfmt_timing.sv
module vfmt_timing #(
  parameter int HW = 11,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] act_slots,
  input  logic [HW-1:0] line_slots,
  input  logic [VW-1:0] line_first,
  input  logic [VW-1:0] line_last,
  input  logic [VW-1:0] frame_lines,
  output logic          phase,
  output logic          slot_active,
  output logic          last_slot,
  output logic          last_line,
  output logic          field
);
  localparam logic [HW-1:0] H_ONE = 1;
  localparam logic [VW-1:0] V_ONE = 1;

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;

  assign last_slot   = (h_q == line_slots - H_ONE);
  assign last_line   = (v_q == frame_lines - V_ONE);
  assign slot_active = (h_q < act_slots) && (v_q >= line_first) && (v_q <= line_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      h_q   <= '0;
      v_q   <= '0;
      field <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        if (last_slot) begin
          h_q <= '0;
          if (last_line) begin
            v_q   <= '0;
            field <= ~field;
          end else begin
            v_q <= v_q + V_ONE;
          end
        end else begin
          h_q <= h_q + H_ONE;
        end
      end
    end
  end

  // R2: the slot index stays inside the programmed line length
  p_slot_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_q < line_slots);
  // R2: the slot index moves only after the second cycle of a slot
  p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(phase) |-> $stable(h_q));
endmodule

// File: rtl/vfmt_dv_gen.sv
module vfmt_dv_gen (
  input  logic phase,
  input  logic slot_active,
  input  logic fill,
  input  logic all_lines,
  input  logic no_duty,
  output logic dv_raw
);
  logic starved;

  always_comb begin
    starved = slot_active && !fill;
    if (all_lines)
      dv_raw = !phase && !starved;
    else
      dv_raw = fill && (no_duty || !phase);
  end
endmodule

// File: rtl/vfmt_mux.sv
module vfmt_mux
  import vfmt_pkg::*;
(
  input  logic       wide,
  input  logic       phase,
  input  logic       fill,
  input  logic [7:0] in_y,
  input  logic [7:0] in_c,
  input  pix_t       hold,
  output logic [15:0] bus
);
  always_comb begin
    if (!fill) begin
      if (wide)       bus = {Y_BLANK, C_BLANK};
      else if (phase) bus = {Y_BLANK, 8'h00};
      else            bus = {C_BLANK, 8'h00};
    end else if (wide) begin
      bus = phase ? {hold.y, hold.c} : {in_y, in_c};
    end else begin
      bus = phase ? {hold.y, 8'h00} : {in_c, 8'h00};
    end
  end
endmodule

// File: rtl/vfmt_out.sv
module vfmt_out
  import vfmt_pkg::*;
#(
  parameter int HW = 11,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          dv_all_lines,
  input  logic          dv_no_duty,
  input  logic          dv_active_low,
  input  logic [HW-1:0] act_slots,
  input  logic [HW-1:0] line_slots,
  input  logic [VW-1:0] line_first,
  input  logic [VW-1:0] line_last,
  input  logic [VW-1:0] frame_lines,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_y,
  input  logic [7:0]    in_c,
  output logic [15:0]   pix_o,
  output logic          blank_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          field_o,
  output logic          dvalid_o
);
  logic phase, slot_active, last_slot, last_line, field;
  logic took_q, fill, dv_raw, dv_q;
  pix_t hold_q;
  logic [15:0] bus_d;

  vfmt_timing #(.HW(HW), .VW(VW)) u_tim (
    .clk(clk), .rst_n(rst_n),
    .act_slots(act_slots), .line_slots(line_slots),
    .line_first(line_first), .line_last(line_last), .frame_lines(frame_lines),
    .phase(phase), .slot_active(slot_active),
    .last_slot(last_slot), .last_line(last_line), .field(field)
  );

  assign in_ready = slot_active && !phase;
  assign fill     = slot_active && (phase ? took_q : in_valid);

  vfmt_dv_gen u_dv (
    .phase(phase), .slot_active(slot_active), .fill(fill),
    .all_lines(dv_all_lines), .no_duty(dv_no_duty), .dv_raw(dv_raw)
  );

  vfmt_mux u_mux (
    .wide(wide_mode), .phase(phase), .fill(fill),
    .in_y(in_y), .in_c(in_c), .hold(hold_q), .bus(bus_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      took_q  <= 1'b0;
      hold_q  <= '{y: Y_BLANK, c: C_BLANK};
      pix_o   <= {Y_BLANK, C_BLANK};
      blank_o <= 1'b1;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      field_o <= 1'b0;
      dv_q    <= 1'b0;
    end else begin
      took_q <= in_ready && in_valid;
      if (in_ready && in_valid) hold_q <= '{y: in_y, c: in_c};
      pix_o   <= bus_d;
      blank_o <= !fill;
      hsync_o <= last_slot;
      vsync_o <= last_line;
      field_o <= field;
      dv_q    <= dv_raw;
    end
  end

  assign dvalid_o = dv_q ^ dv_active_low;

  // R6: an accepted sample shows up as an unblanked slot
  p_take_shows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> !blank_o);
  // R6: a starved slot stays blank for both of its cycles
  p_starve_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> blank_o ##1 blank_o);
  // R5: wide blanking carries the fixed codes
  p_blank_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_o && wide_mode) |-> (pix_o == 16'h1080));
  // R7: the half-duty strobe never lasts two cycles
  p_half_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dv_all_lines && !dv_no_duty && dv_q) |=> !dv_q);
  // R8: the full-slot strobe covers the second cycle too
  p_full_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dv_all_lines && dv_no_duty && $rose(dv_q)) |=> dv_q);
  // R11: the field flag flips only right after the last line
  p_field_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (field_o != $past(field_o)) |-> $past(vsync_o));
endmodule

// File: tb/sim_vfmt_out.sv
`timescale 1ns/1ps
module sim_vfmt_out;
  localparam int HW = 11;
  localparam int VW = 10;
  localparam int ACT = 4, SLOTS = 6, FIRST = 1, LAST = 2, LINES = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic wide_mode = 1'b0, dv_all_lines = 1'b0, dv_no_duty = 1'b0, dv_active_low = 1'b0;
  logic in_valid = 1'b1;
  logic in_ready;
  logic [7:0] in_y = 8'h20, in_c = 8'h40;
  logic [15:0] pix_o;
  logic blank_o, hsync_o, vsync_o, field_o, dvalid_o;

  vfmt_out #(.HW(HW), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wide_mode(wide_mode), .dv_all_lines(dv_all_lines),
    .dv_no_duty(dv_no_duty), .dv_active_low(dv_active_low),
    .act_slots(HW'(ACT)), .line_slots(HW'(SLOTS)),
    .line_first(VW'(FIRST)), .line_last(VW'(LAST)), .frame_lines(VW'(LINES)),
    .in_valid(in_valid), .in_ready(in_ready), .in_y(in_y), .in_c(in_c),
    .pix_o(pix_o), .blank_o(blank_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .field_o(field_o), .dvalid_o(dvalid_o)
  );

  typedef struct { bit taken; logic [7:0] c; logic [7:0] y; } ent_t;
  ent_t sb[$];

  int n_run = 0, n_fail = 0;
  bit starve = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic set_data(int p);
    in_y = 8'(32 + p);
    in_c = p[0] ? 8'(192 + p) : 8'(64 + p);
  endtask

  // driver: records every ready opportunity in the scoreboard
  task automatic drive_loop;
    int p = 0, opp = 0;
    bit hs, seen;
    forever begin
      @(negedge clk);
      seen = 0; hs = 0;
      if (!rst_n) begin
        p = 0; opp = 0; sb.delete();
        set_data(0); in_valid = 1'b1;
      end else if (in_ready) begin
        sb.push_back('{in_valid, in_c, in_y});
        hs = in_valid; seen = 1; opp++;
      end
      @(posedge clk); #1;
      if (seen) begin
        if (hs) p++;
        set_data(p);
        in_valid = !(starve && (opp == 5 || opp == 6));
      end
    end
  endtask

  // monitor: outputs at this negedge reflect counter state index k-1
  task automatic monitor_loop;
    int k = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) k = 0;
      else begin
        int m, ph, sl, ln, fr;
        bit act, fill, raw;
        ent_t e;
        logic [15:0] eb;
        string tb, td;
        k++;
        m = k - 1;
        ph = m % 2; sl = (m / 2) % SLOTS; ln = (m / (2*SLOTS)) % LINES;
        fr = m / (2*SLOTS*LINES);
        act = (sl < ACT) && (ln >= FIRST) && (ln <= LAST);
        fill = 0;
        e = '{0, 8'h00, 8'h00};
        if (act) begin
          if (sb.size() == 0) check(0, "R6", "scoreboard empty", 0, 1);
          else begin
            e = sb[0];
            fill = e.taken;
            if (ph == 1) void'(sb.pop_front());
          end
        end
        if (!fill) eb = wide_mode ? 16'h1080 : (ph == 1 ? 16'h1000 : 16'h8000);
        else if (wide_mode) eb = {e.y, e.c};
        else eb = ph == 1 ? {e.y, 8'h00} : {e.c, 8'h00};
        tb = fill ? (wide_mode ? "R4" : "R3") : (act ? "R6" : "R5");
        check(pix_o == eb, tb, "pix_o", pix_o, eb);
        check(blank_o == !fill, act && !fill ? "R6" : "R2", "blank_o", blank_o, !fill);
        raw = dv_all_lines ? (ph == 0 && !(act && !fill)) : (fill && (dv_no_duty || ph == 0));
        td = dv_active_low ? "R10" : (dv_all_lines ? "R9" : (dv_no_duty ? "R8" : "R7"));
        check(dvalid_o == (raw ^ dv_active_low), td, "dvalid_o", dvalid_o, raw ^ dv_active_low);
        check(hsync_o == (sl == SLOTS-1), "R11", "hsync_o", hsync_o, sl == SLOTS-1);
        check(vsync_o == (ln == LINES-1), "R11", "vsync_o", vsync_o, ln == LINES-1);
        check(field_o == fr[0], "R11", "field_o", field_o, fr[0]);
      end
    end
  endtask

  task automatic run_cfg(bit w, bit al, bit nd, bit pol, bit st);
    rst_n = 1'b0;
    wide_mode = w; dv_all_lines = al; dv_no_duty = nd; dv_active_low = pol; starve = st;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset levels
    check(pix_o == 16'h1080, "R1", "reset pix_o", pix_o, 16'h1080);
    check(blank_o == 1'b1, "R1", "reset blank_o", blank_o, 1);
    check(dvalid_o == pol, "R1", "reset dvalid_o", dvalid_o, pol);
    check({hsync_o, vsync_o, field_o} == 3'b000, "R1", "reset syncs",
          {hsync_o, vsync_o, field_o}, 0);
    #1 rst_n = 1'b1;
    repeat (2*2*SLOTS*LINES + 6) @(negedge clk);
  endtask

  initial begin
    fork
      drive_loop();
      monitor_loop();
    join_none
    run_cfg(0, 0, 0, 0, 0); // R3 R5 R7 narrow, half duty
    run_cfg(0, 0, 1, 0, 0); // R8 full-slot strobe
    run_cfg(1, 1, 1, 1, 1); // R9 R10 R6 all lines, inverted, starved
    run_cfg(1, 0, 0, 0, 1); // R4 R6 wide, starved
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule